// File: doc/BRIEF.md
# Deferred Store-Data Mask Patcher

Store-type and DMA-type commands have their trace entry written at command time with the deferred field set to zero. This block follows the data phases that arrive some cycles later. They arrive in the same order as the commands that own them. For each owning command it builds the deferred value: a write-mask summary for a store, or a beat count for a DMA. It then emits a patch that carries the buffer index of the entry to update, together with the finished field.

Commands announce themselves on a one-cycle strobe. Each strobe carries a kind (none, store, DMA, or response) and the entry index, and every kind except none reserves a slot in a small owner queue. Response commands own data phases but are never recorded, so their phases are consumed and thrown away. This keeps later data aligned with the right command.

Patches leave on a valid/ready interface. Ready is high only in cycles when the single buffer port is not taken by a command-entry write. A patch that completes while the port is free and nothing is queued is presented in that same cycle. Otherwise it waits in a four-deep patch FIFO. Once asserted, valid stays high until the patch is accepted. When the FIFO is full and the port is still busy, a new patch overwrites the oldest queued patch, and that entry's field stays zero. The data-phase input has no back-pressure.

Top module: `store_mask_patcher`

## Requirements
- R1: After reset `patch_valid` is low, and it goes high only in a cycle that ends a data phase (`dat_valid` and `dat_eow` both high) or while a patch is still waiting.
- R2: Kinds are encoded 0 none, 1 store, 2 DMA, 3 response. Kind 0 reserves no slot. The other kinds are queued in command order, and each data phase belongs to the oldest queued command. A data phase always starts at least one cycle after its command, and never while the queue is empty.
- R3: A store patch field is {chunk map[23:16], byte mask[15:0]}. Bit k of the chunk map is set if some valid beat with `dat_adr`=k has a non-zero mask. The byte mask is the OR of the masks of all valid beats, including the end-of-write beat.
- R4: A DMA patch field is the number of valid beats in its data phase, including the end-of-write beat, zero-extended to 24 bits.
- R5: A data phase owned by a response command produces no patch, but still frees its queue slot.
- R6: `patch_idx` equals the index that was given with the owning command.
- R7: With the FIFO empty and `port_free` high, a patch is shown on the outputs in the cycle its end-of-write beat arrives, and it is accepted in that cycle.
- R8: While `port_free` is low, a valid patch remains valid. Queued patches leave in completion order, one per cycle in which `port_free` is high.
- R9: The patch FIFO holds 4 patches. A patch that completes while the FIFO is full and the port is busy drops the oldest queued patch.
- R10: Cycles with `dat_valid` low change no accumulated state, whatever `dat_eow`, `dat_adr` and `dat_mask` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 2 | 0 none, 1 store, 2 DMA, 3 response |
| cmd_idx | input | IDX_W | Buffer index of the command's entry |
| dat_valid | input | 1 | Data beat valid |
| dat_eow | input | 1 | Last beat of the data phase |
| dat_adr | input | 3 | 16-byte chunk number within the line |
| dat_mask | input | 16 | Byte write mask of the beat |
| port_free | input | 1 | Ready: buffer port not used by a command write |
| patch_valid | output | 1 | Patch available |
| patch_idx | output | IDX_W | Entry index to patch |
| patch_field | output | 24 | Deferred field value |

## Verification
The assertions check on every cycle that a valid patch is never withdrawn while the port is busy, that no patch appears without a completed data phase or an earlier pending one, that response-owned phases stay silent, that FIFO occupancy stays bounded and stays full when a patch overwrites, and that data never arrives with no owner. The field values, the index carried from command to patch, the drain order after a busy period, and which patches survive an overflow can only be shown by the bench scenarios. These sweep all chunk positions for stores, DMA lengths from 1 to 8 with idle gaps, interleaved owners, and a six-patch burst against the four-deep FIFO.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int CHUNKS  = 8;
  localparam int ADR_W   = $clog2(CHUNKS);
  localparam int MASK_W  = 16;
  localparam int FIELD_W = CHUNKS + MASK_W;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_STORE = 2'd1,
    CK_DMA   = 2'd2,
    CK_RESP  = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/smp_owner_q.sv
module smp_owner_q #(
  parameter int IDX_W = 6,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [1:0]       kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             pop_i,
  output logic             empty_o,
  output logic             full_o,
  output logic [1:0]       head_kind_o,
  output logic [IDX_W-1:0] head_idx_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]       kind_q [DEPTH];
  logic [IDX_W-1:0] idx_q  [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : PW'(p + 1'b1);
  endfunction

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      kind_q[wp] <= kind_i;
      idx_q[wp]  <= idx_i;
    end
  end

  assign head_kind_o = kind_q[rp];
  assign head_idx_o  = idx_q[rp];
endmodule

// File: rtl/smp_accum.sv
module smp_accum
  import smp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_v_i,
  input  logic               eow_i,
  input  logic [ADR_W-1:0]   adr_i,
  input  logic [MASK_W-1:0]  mask_i,
  output logic [FIELD_W-1:0] store_field_o,
  output logic [FIELD_W-1:0] dma_field_o
);
  logic [CHUNKS-1:0]  acc_map, beat_map, map_all;
  logic [MASK_W-1:0]  acc_mask, mask_all;
  logic [FIELD_W-1:0] acc_len, len_all;

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    assign beat_map[c] = (adr_i == ADR_W'(c)) && (|mask_i);
  end

  assign map_all  = acc_map | beat_map;
  assign mask_all = acc_mask | mask_i;
  assign len_all  = acc_len + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_map  <= '0;
      acc_mask <= '0;
      acc_len  <= '0;
    end else if (beat_v_i) begin
      if (eow_i) begin
        acc_map  <= '0;
        acc_mask <= '0;
        acc_len  <= '0;
      end else begin
        acc_map  <= map_all;
        acc_mask <= mask_all;
        acc_len  <= len_all;
      end
    end
  end

  assign store_field_o = {map_all, mask_all};
  assign dma_field_o   = len_all;
endmodule

// File: rtl/smp_patch_fifo.sv
module smp_patch_fifo #(
  parameter int W     = 30,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, empty, do_pop, drop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : PW'(p + 1'b1);
  endfunction

  assign full   = (cnt_o == CW'(DEPTH));
  assign empty  = (cnt_o == '0);
  assign do_pop = pop_i && !empty;
  assign drop   = push_i && !do_pop && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_o <= '0;
    end else begin
      if (push_i)         wp <= bump(wp);
      if (do_pop || drop) rp <= bump(rp);
      if (push_i && !do_pop && !full) cnt_o <= cnt_o + 1'b1;
      else if (do_pop && !push_i)     cnt_o <= cnt_o - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= din_i;
  end

  assign head_o = mem[rp];
endmodule

// File: rtl/store_mask_patcher.sv
module store_mask_patcher
  import smp_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int OWN_DEPTH = 4,
  parameter int PF_DEPTH  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_kind,
  input  logic [IDX_W-1:0]   cmd_idx,
  input  logic               dat_valid,
  input  logic               dat_eow,
  input  logic [ADR_W-1:0]   dat_adr,
  input  logic [MASK_W-1:0]  dat_mask,
  input  logic               port_free,
  output logic               patch_valid,
  output logic [IDX_W-1:0]   patch_idx,
  output logic [FIELD_W-1:0] patch_field
);
  localparam int PATCH_W = IDX_W + FIELD_W;
  localparam int PCW     = $clog2(PF_DEPTH + 1);

  logic             oq_empty, oq_full;
  logic [1:0]       oq_head_kind;
  logic [IDX_W-1:0] oq_head_idx;
  cmd_kind_e        head_kind;
  logic             phase_end, new_v, pf_push, pf_pop;
  logic [FIELD_W-1:0] store_field, dma_field, new_field;
  logic [PATCH_W-1:0] new_patch, pf_head, out_patch;
  logic [PCW-1:0]   pf_cnt;

  assign phase_end = dat_valid && dat_eow;
  assign head_kind = cmd_kind_e'(oq_head_kind);

  smp_owner_q #(.IDX_W(IDX_W), .DEPTH(OWN_DEPTH)) u_oq (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (cmd_valid && (cmd_kind_e'(cmd_kind) != CK_NONE)),
    .kind_i      (cmd_kind),
    .idx_i       (cmd_idx),
    .pop_i       (phase_end),
    .empty_o     (oq_empty),
    .full_o      (oq_full),
    .head_kind_o (oq_head_kind),
    .head_idx_o  (oq_head_idx)
  );

  smp_accum u_acc (
    .clk           (clk),
    .rst_n         (rst_n),
    .beat_v_i      (dat_valid),
    .eow_i         (dat_eow),
    .adr_i         (dat_adr),
    .mask_i        (dat_mask),
    .store_field_o (store_field),
    .dma_field_o   (dma_field)
  );

  assign new_v     = phase_end && !oq_empty &&
                     ((head_kind == CK_STORE) || (head_kind == CK_DMA));
  assign new_field = (head_kind == CK_STORE) ? store_field : dma_field;
  assign new_patch = {oq_head_idx, new_field};

  assign pf_pop  = (pf_cnt != '0) && port_free;
  assign pf_push = new_v && !((pf_cnt == '0) && port_free);

  smp_patch_fifo #(.W(PATCH_W), .DEPTH(PF_DEPTH)) u_pf (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (pf_push),
    .din_i  (new_patch),
    .pop_i  (pf_pop),
    .head_o (pf_head),
    .cnt_o  (pf_cnt)
  );

  assign out_patch   = (pf_cnt != '0) ? pf_head : new_patch;
  assign patch_valid = (pf_cnt != '0) || new_v;
  assign patch_idx   = out_patch[PATCH_W-1:FIELD_W];
  assign patch_field = out_patch[FIELD_W-1:0];
endmodule

// File: rtl/smp_checker.sv
module smp_checker #(
  parameter int PF_DEPTH = 4,
  localparam int PCW     = $clog2(PF_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dat_valid,
  input logic           dat_eow,
  input logic           port_free,
  input logic           patch_valid,
  input logic [1:0]     head_kind,
  input logic           q_empty,
  input logic [PCW-1:0] pf_cnt
);
  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    patch_valid && !port_free |=> patch_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_valid && dat_eow) && !$past(patch_valid) |-> !patch_valid);

  a_r5_resp_silent: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && dat_eow && !q_empty && head_kind == 2'd3 && pf_cnt == '0
    |-> !patch_valid);

  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pf_cnt <= PCW'(PF_DEPTH));

  a_r9_overwrite_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    pf_cnt == PCW'(PF_DEPTH) && !port_free && dat_valid && dat_eow && !q_empty &&
    (head_kind == 2'd1 || head_kind == 2'd2) |=> pf_cnt == PCW'(PF_DEPTH));

  a_r2_data_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> !q_empty);
endmodule

bind store_mask_patcher smp_checker #(.PF_DEPTH(PF_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dat_valid   (dat_valid),
  .dat_eow     (dat_eow),
  .port_free   (port_free),
  .patch_valid (patch_valid),
  .head_kind   (oq_head_kind),
  .q_empty     (oq_empty),
  .pf_cnt      (pf_cnt)
);

// File: tb/store_mask_patcher_tb.sv
`timescale 1ns/1ps
module store_mask_patcher_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_kind = 0;
  logic [5:0]  cmd_idx = 0;
  logic        dat_valid = 0, dat_eow = 0;
  logic [2:0]  dat_adr = 0;
  logic [15:0] dat_mask = 0;
  logic        port_free = 1;
  logic        patch_valid;
  logic [5:0]  patch_idx;
  logic [23:0] patch_field;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  store_mask_patcher u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_idx(cmd_idx), .dat_valid(dat_valid), .dat_eow(dat_eow),
    .dat_adr(dat_adr), .dat_mask(dat_mask), .port_free(port_free),
    .patch_valid(patch_valid), .patch_idx(patch_idx), .patch_field(patch_field)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] k, input logic [5:0] i);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_kind = k; cmd_idx = i;
    dat_valid = 0; dat_eow = 0; dat_adr = 0; dat_mask = 0;
    @(negedge clk);
  endtask

  task automatic beat(input logic [2:0] a, input logic [15:0] m, input logic e);
    @(posedge clk); #1;
    cmd_valid = 0; cmd_kind = 0; cmd_idx = 0;
    dat_valid = 1; dat_eow = e; dat_adr = a; dat_mask = m;
    @(negedge clk);
  endtask

  // invalid cycle with garbage on the data lines (R10)
  task automatic gap();
    @(posedge clk); #1;
    cmd_valid = 0; dat_valid = 0; dat_eow = 1; dat_adr = 3'd5; dat_mask = 16'hFFFF;
    @(negedge clk);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    cmd_valid = 0; dat_valid = 0; dat_eow = 0; dat_adr = 0; dat_mask = 0;
    @(negedge clk);
  endtask

  task automatic expect_patch(input string tag, input logic [5:0] i, input logic [23:0] f);
    check({tag, " valid"}, 32'(patch_valid), 32'd1);
    check({tag, " idx"},   32'(patch_idx),   32'(i));
    check({tag, " field"}, 32'(patch_field), 32'(f));
  endtask

  task automatic drain_expect(input string tag, input logic [5:0] i, input logic [23:0] f);
    @(posedge clk); #1;
    port_free = 1; cmd_valid = 0; dat_valid = 0; dat_eow = 0; dat_mask = 0;
    @(negedge clk);
    expect_patch(tag, i, f);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", 32'(patch_valid), 32'd0);
    rst_n = 1;
    idle();
    check("R1 valid after reset", 32'(patch_valid), 32'd0);

    // R3 / R6 / R7: store sweep over every chunk position
    for (int a = 0; a < 8; a++) begin
      logic [2:0]  az, a1, a3;
      logic [15:0] m1, m3;
      logic [7:0]  map;
      az = 3'((a + 5) % 8); a1 = 3'(a); a3 = 3'((a + 3) % 8);
      m1 = 16'h1 << (2 * a);
      m3 = ~(16'h1 << a);
      map = (8'h1 << a1) | (8'h1 << a3);
      cmd(2'd1, 6'(a + 1));
      beat(az, 16'h0, 1'b0);
      beat(a1, m1, 1'b0);
      check("R1 no patch mid-phase", 32'(patch_valid), 32'd0);
      beat(a3, m3, 1'b1);
      expect_patch("R3 R6 R7 store", 6'(a + 1), {map, m1 | m3});
      idle();
      check("R7 accepted at once", 32'(patch_valid), 32'd0);
    end

    // R4 / R10: DMA lengths 1..8, gaps inserted in even lengths
    for (int n = 1; n <= 8; n++) begin
      cmd(2'd2, 6'(20 + n));
      for (int b = 0; b < n - 1; b++) begin
        beat(3'(b), 16'h00F0, 1'b0);
        if (n % 2 == 0) gap();
      end
      beat(3'd1, 16'h0001, 1'b1);
      expect_patch("R4 R10 dma length", 6'(20 + n), 24'(n));
    end

    // R10: store with gaps carrying garbage
    cmd(2'd1, 6'd29);
    gap();
    beat(3'd2, 16'h0010, 1'b0);
    gap();
    beat(3'd2, 16'h0100, 1'b1);
    expect_patch("R10 gaps ignored", 6'd29, {8'h04, 16'h0110});

    // R5: response owner consumes its phase silently
    cmd(2'd3, 6'd30);
    cmd(2'd1, 6'd31);
    beat(3'd2, 16'hF0F0, 1'b0);
    beat(3'd3, 16'h0000, 1'b1);
    check("R5 response silent", 32'(patch_valid), 32'd0);
    beat(3'd7, 16'h8001, 1'b1);
    expect_patch("R5 next owner", 6'd31, {8'h80, 16'h8001});

    // R2: kind none takes no slot
    cmd(2'd0, 6'd40);
    cmd(2'd1, 6'd41);
    beat(3'd0, 16'h00FF, 1'b1);
    expect_patch("R2 none not queued", 6'd41, {8'h01, 16'h00FF});

    // R2: two owners queued back to back
    cmd(2'd1, 6'd50);
    cmd(2'd2, 6'd51);
    beat(3'd1, 16'h0F00, 1'b1);
    expect_patch("R2 first owner", 6'd50, {8'h02, 16'h0F00});
    beat(3'd0, 16'h0001, 1'b0);
    beat(3'd0, 16'h0001, 1'b1);
    expect_patch("R2 second owner", 6'd51, 24'd2);
    idle();

    // R8: busy port queues patches, drain in order
    port_free = 0;
    for (int k = 0; k < 3; k++) begin
      cmd(2'd1, 6'(60 + k));
      beat(3'(k), 16'h1 << k, 1'b1);
      idle();
      expect_patch("R8 held while busy", 6'd60, {8'h01, 16'h0001});
    end
    for (int k = 0; k < 3; k++)
      drain_expect("R8 drain order", 6'(60 + k), {8'h1 << k, 16'h1 << k});
    idle();
    check("R8 drained", 32'(patch_valid), 32'd0);

    // R9: six patches against a four-deep FIFO
    port_free = 0;
    for (int k = 0; k < 6; k++) begin
      cmd(2'd1, 6'(10 + k));
      beat(3'(k), 16'h1 << k, 1'b1);
    end
    idle();
    check("R9 valid while full", 32'(patch_valid), 32'd1);
    for (int k = 2; k < 6; k++)
      drain_expect("R9 survivors", 6'(10 + k), {8'h1 << k, 16'h1 << k});
    idle();
    check("R9 oldest dropped", 32'(patch_valid), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule